// File: doc/BRIEF.md
# Two-Wire Wiper Setting Slave

This block is a two-wire bus slave that owns an 8-bit wiper setting and a shutdown flag. It samples the bus clock and data lines with the system clock and detects start and stop conditions. It then takes in a 7-bit address whose six upper bits are fixed and whose lowest bit comes from a strap pin. This lets two copies share one bus.

A write transfer carries a command byte after the address. The command byte holds a midscale-reset flag and a shutdown flag. One or more data bytes follow, and each one is loaded into the wiper setting. A read transfer has no command byte: the slave shifts out the current wiper setting at once. The slave acknowledges a byte and drives its read data only by enabling an open-drain pull-down. The enable changes only while the bus clock is low. The wiper setting starts at midscale when reset.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset, `wiper_o` is 0x80, `shutdown_o` is 0 and `sda_oe_o` is 0.
- R2: The device address is binary 010110 followed by `addr_pin_i`, and bit 0 of the first byte is the direction (1 = master reads). On a match the slave pulls the data line low during the ninth clock. On a mismatch it never enables `sda_oe_o` until the next start, and it changes no state.
- R3: In a write transfer, the slave acknowledges the command byte and then a data byte. With the command byte at 0x00, the data byte becomes the new `wiper_o`.
- R4: Each further data byte in the same write transfer is acknowledged and replaces `wiper_o`, so the last byte sent is the one that remains.
- R5: Command bit 6 set forces `wiper_o` to 0x80 when the command byte completes. Data bytes later in that same transfer leave it at 0x80.
- R6: Command bit 5 loads `shutdown_o` (1 = shut down, 0 = active). While shut down, `wiper_o` still accepts data bytes and keeps its value.
- R7: Command bits 7 and 4..0 have no effect: command 0x9F behaves like 0x00.
- R8: In a read transfer, the slave drives `wiper_o` MSB first straight after the address acknowledge. A master acknowledge makes it send the value again. A master no-acknowledge releases the line.
- R9: A start condition in the middle of a byte restarts address reception. A stop condition returns the slave to idle from any state, drops `sda_oe_o`, and leaves `wiper_o` unchanged after a partial byte.
- R10: `sda_oe_o` changes only while the bus clock is low. `wiper_o` and `shutdown_o` change only while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| addr_pin_i | input | 1 | Strap setting the lowest address bit |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 = drive low) |
| wiper_o | output | 8 | Current wiper setting |
| shutdown_o | output | 1 | Shutdown flag from the last command byte |

## Verification
The checker covers the behaviours that hold on every cycle. The pull-down enable moves only while the clock is low, and the wiper and shutdown flag move only while it is high. A detected start or stop always releases the line, and the value seen after reset is midscale. The bench scenarios cover the behaviours that need a whole transfer. These are address matching on both strap levels, the effect of each command bit, repeated data bytes, repeated read bytes under master acknowledge, and recovery after a restart or stop in the middle of a byte.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_RCONT
  } st_e;

  typedef enum logic [1:0] {
    FLD_ADDR,
    FLD_INSTR,
    FLD_DATA
  } fld_e;
endpackage

// File: rtl/wiper_i2c_line_sync.sv
module wiper_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // data edge while clock stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/wiper_i2c_wiper_reg.sv
module wiper_i2c_wiper_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mid_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         sd_we_i,
  input  logic         sd_i,
  output logic [W-1:0] wiper_o,
  output logic         shutdown_o
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_o    <= MID;
      shutdown_o <= 1'b0;
    end else begin
      if (mid_i)       wiper_o <= MID;
      else if (load_i) wiper_o <= data_i;
      if (sd_we_i)     shutdown_o <= sd_i;
    end
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b010110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_pin_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] wiper_o,
  output logic              shutdown_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;

  wiper_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  st_e               st_q;
  fld_e              fld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sr_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q, rs_q, ack_on_q, oe_q;

  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done, addr_hit;
  logic              mid_w, load_w, sd_we_w;

  assign rx_byte   = {sr_q, sda_s};
  assign byte_done = (st_q == ST_RX) && scl_rise && (cnt_q == CNT_W'(BYTE_W - 1));
  assign addr_hit  = (rx_byte[BYTE_W-1:1] == {ADDR_HI, addr_pin_i});
  assign sd_we_w   = byte_done && (fld_q == FLD_INSTR);
  assign mid_w     = sd_we_w && rx_byte[6];
  assign load_w    = byte_done && (fld_q == FLD_DATA) && !rs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      fld_q    <= FLD_ADDR;
      cnt_q    <= '0;
      sr_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      rs_q     <= 1'b0;
      ack_on_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_w) begin
      st_q     <= ST_RX;
      fld_q    <= FLD_ADDR;
      cnt_q    <= '0;
      ack_on_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (stop_w) begin
      st_q     <= ST_IDLE;
      ack_on_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: if (scl_rise) begin
          sr_q  <= rx_byte[BYTE_W-2:0];
          cnt_q <= cnt_q + CNT_W'(1);
          if (byte_done) begin
            unique case (fld_q)
              FLD_ADDR: begin
                rw_q <= sda_s;
                st_q <= addr_hit ? ST_ACK : ST_IDLE;
              end
              FLD_INSTR: begin
                rs_q <= rx_byte[6];
                st_q <= ST_ACK;
              end
              default: st_q <= ST_ACK;
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!ack_on_q) begin
            ack_on_q <= 1'b1;
            oe_q     <= 1'b1;
          end else begin
            ack_on_q <= 1'b0;
            cnt_q    <= '0;
            if (fld_q == FLD_ADDR && rw_q) begin
              st_q <= ST_TX;
              tx_q <= wiper_o;
              oe_q <= ~wiper_o[BYTE_W-1];
            end else begin
              st_q  <= ST_RX;
              oe_q  <= 1'b0;
              fld_q <= (fld_q == FLD_ADDR) ? FLD_INSTR : FLD_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_q <= cnt_q + CNT_W'(1);
          if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W)) begin
              oe_q <= 1'b0;
              st_q <= ST_RACK;
            end else begin
              oe_q <= ~tx_q[BYTE_W-2];
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        // master acknowledge low asks for another byte
        ST_RACK: if (scl_rise) st_q <= sda_s ? ST_IDLE : ST_RCONT;
        ST_RCONT: if (scl_fall) begin
          st_q  <= ST_TX;
          cnt_q <= '0;
          tx_q  <= wiper_o;
          oe_q  <= ~wiper_o[BYTE_W-1];
        end
        default: ;
      endcase
    end
  end

  wiper_i2c_wiper_reg #(.W(BYTE_W)) u_wiper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mid_i      (mid_w),
    .load_i     (load_w),
    .data_i     (rx_byte),
    .sd_we_i    (sd_we_w),
    .sd_i       (rx_byte[5]),
    .wiper_o    (wiper_o),
    .shutdown_o (shutdown_o)
  );

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/wiper_i2c_slave_chk.sv
module wiper_i2c_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic [7:0] wiper_o,
  input logic       shutdown_o,
  input logic       start_i,
  input logic       stop_i
);
  p_reset_mid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (wiper_o == 8'h80 && !shutdown_o && !sda_oe_o));

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  p_wiper_scl_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> scl_i);

  p_shutdown_scl_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shutdown_o) |-> scl_i);

  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || start_i) |=> !sda_oe_o);
endmodule

bind wiper_i2c_slave wiper_i2c_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .wiper_o    (wiper_o),
  .shutdown_o (shutdown_o),
  .start_i    (start_w),
  .stop_i     (stop_w)
);

// File: tb/wiper_i2c_slave_tb_top.sv
module wiper_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4 * CLK_PERIOD;

  typedef struct {
    string req;
    int    val;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe, shdn, oe_seen = 1'b0, done = 1'b0;
  logic [7:0] wiper;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, fails = 0, r10_bad = 0;
  item_t exp_q[$], obs_q[$];

  wiper_i2c_slave dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .addr_pin_i (strap),
    .sda_oe_o   (sda_oe),
    .wiper_o    (wiper),
    .shutdown_o (shdn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (sda_oe) oe_seen = 1'b1;
  always @(sda_oe) if (rst_n && scl_m) r10_bad++;

  task automatic chk(input string req, input int act, input int exp);
    item_t e, o;
    e.req = req; e.val = exp;
    o.req = "";  o.val = act;
    exp_q.push_back(e);
    obs_q.push_back(o);
  endtask

  // monitor: pops observed results against queued expectations
  initial begin
    item_t o, e;
    forever begin
      wait (obs_q.size() != 0);
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if (o.val != e.val) begin
        fails++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", e.req, o.val, e.val);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; #Q; scl_m = 1'b1; #Q; s = sda_bus; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!m_ack, s);
  endtask

  task automatic wr_begin(input logic [7:0] abyte, input logic [7:0] instr, input string req);
    logic a;
    bus_start();
    send_byte(abyte, a);
    chk({req, " address ack"}, a, 1);
    send_byte(instr, a);
    chk({req, " command ack"}, a, 1);
  endtask

  task automatic wr_data(input logic [7:0] d, input logic [7:0] exp_w, input string req);
    logic a;
    send_byte(d, a);
    chk({req, " data ack"}, a, 1);
    chk({req, " wiper"}, wiper, exp_w);
  endtask

  task automatic rd_one(input logic [7:0] abyte, input logic [7:0] exp_v, input string req);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(abyte, a);
    chk({req, " read address ack"}, a, 1);
    recv_byte(1'b0, b);
    chk({req, " read data"}, b, exp_v);
    bus_stop();
  endtask

  initial begin
    logic a, s;
    logic [7:0] b;
    #(10*CLK_PERIOD);
    rst_n = 1'b1;
    #Q;
    chk("R1 wiper", wiper, 8'h80);
    chk("R1 shutdown", shdn, 0);
    chk("R1 sda_oe", sda_oe, 0);

    // strap low: write 0x58, read 0x59
    wr_begin(8'h58, 8'h00, "R3");
    wr_data(8'h3C, 8'h3C, "R3");
    bus_stop();

    wr_begin(8'h58, 8'h00, "R4");
    wr_data(8'h11, 8'h11, "R4");
    wr_data(8'h22, 8'h22, "R4");
    wr_data(8'hA5, 8'hA5, "R4");
    bus_stop();

    wr_begin(8'h58, 8'h9F, "R7");
    wr_data(8'h5A, 8'h5A, "R7");
    bus_stop();
    chk("R7 shutdown", shdn, 0);

    wr_begin(8'h58, 8'h40, "R5");
    chk("R5 wiper after command", wiper, 8'h80);
    wr_data(8'h07, 8'h80, "R5");
    bus_stop();

    wr_begin(8'h58, 8'h20, "R6");
    chk("R6 shutdown set", shdn, 1);
    wr_data(8'h99, 8'h99, "R6");
    bus_stop();
    rd_one(8'h59, 8'h99, "R6 R8");
    wr_begin(8'h58, 8'h00, "R6");
    bus_stop();
    chk("R6 shutdown cleared", shdn, 0);
    chk("R6 wiper kept", wiper, 8'h99);

    // mismatch: strap low, address with lowest bit 1
    oe_seen = 1'b0;
    bus_start();
    send_byte(8'h5A, a);
    chk("R2 mismatch address ack", a, 0);
    send_byte(8'h00, a);
    chk("R2 mismatch byte ack", a, 0);
    send_byte(8'h12, a);
    chk("R2 mismatch byte ack", a, 0);
    bus_stop();
    chk("R2 mismatch wiper", wiper, 8'h99);
    chk("R2 mismatch never drove", oe_seen, 0);

    strap = 1'b1;
    #Q;
    wr_begin(8'h5A, 8'h00, "R2");
    wr_data(8'hC3, 8'hC3, "R2");
    bus_stop();

    bus_start();
    send_byte(8'h5B, a);
    chk("R8 read address ack", a, 1);
    recv_byte(1'b1, b);
    chk("R8 first byte", b, 8'hC3);
    recv_byte(1'b0, b);
    chk("R8 repeated byte", b, 8'hC3);
    chk("R8 released after nack", sda_oe, 0);
    bus_stop();

    // restart in the middle of a data byte
    wr_begin(8'h5A, 8'h00, "R9");
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_start();
    send_byte(8'h5B, a);
    chk("R9 address after restart ack", a, 1);
    recv_byte(1'b0, b);
    chk("R9 read after restart", b, 8'hC3);
    bus_stop();
    chk("R9 wiper after restart", wiper, 8'hC3);

    // stop in the middle of a data byte
    wr_begin(8'h5A, 8'h00, "R9");
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop();
    chk("R9 released after stop", sda_oe, 0);
    chk("R9 wiper after partial byte", wiper, 8'hC3);
    wr_begin(8'h5A, 8'h00, "R9");
    wr_data(8'h6E, 8'h6E, "R9");
    bus_stop();

    chk("R10 sda_oe changes while clock high", r10_bad, 0);

    wait (obs_q.size() == 0);
    #CLK_PERIOD;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R1..R10 run) actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule